// File: doc/BRIEF.md
# DMA Descriptor Chain Walker

This block is the control engine of one direction of a DMA channel. It walks a linked list of transfer descriptors held in memory. Software loads the low bits of the first descriptor's address and issues a start command. The walker then reads the three words of that descriptor through a single-outstanding request/response read port. It validates the descriptor and presents the buffer address, length and size to the datapath. When the datapath reports that the buffer is finished, the walker follows the next pointer. A next pointer of zero ends the chain, and the walker parks.

The block keeps a rolling record of the three most recently accepted descriptor addresses. It also captures the address of any accepted descriptor that marks the end of a frame. It emits single-cycle event pulses for a rejected descriptor, for an exhausted chain while data is still pending, and for an end-of-frame descriptor. These pulses are meant to set bits in an interrupt register outside the block. A restart command re-mounts the descriptor at the most recently accepted address. A stop command or a channel reset returns the walker to idle.

Top module: `dma_link_walker`

## Requirements
- R1: After reset `park` is 1, `mem_req` and `dsc_valid` are 0, no event pulses, and the three history outputs and `eof_addr` are 0. `mem_req` is never 1 while `park` is 1.
- R2: A start command fetches the descriptor at `{ADDR_HI, start_addr}`. It reads word 0, word 1 and word 2 at that address, +4 and +8, in that order. Each request holds `mem_req` and `mem_addr` steady until `mem_rvalid`.
- R3: Start and restart are acted on only while `park` is 1. Start wins over restart. While the walker is working, both commands are ignored. When stop and start arrive in the same cycle while idle, the walker stays idle.
- R4: Restart fetches the descriptor at the address currently in `hist_cur`.
- R5: Each accepted descriptor shifts the history. `hist_old` takes `hist_prev`, `hist_prev` takes `hist_cur`, and `hist_cur` takes the accepted address. A rejected descriptor leaves the history unchanged.
- R6: An accepted descriptor with word 0 bit 30 set loads its address into `eof_addr` and gives a one-cycle `ev_eof` pulse. This happens in the same cycle that `dsc_valid` rises.
- R7: With `own_chk_en` at 1, a descriptor whose word 0 bit 31 is 0 is rejected. The block pulses `ev_dscr_err` for one cycle and parks. With `own_chk_en` at 0, bit 31 is ignored.
- R8: A descriptor whose word 1 or word 2 has a nonzero bit 1 or bit 0 is rejected with `ev_dscr_err` and park.
- R9: On `buf_done` while a descriptor is held, a nonzero word 2 starts a fetch at that address. A zero word 2 parks the walker, and pulses `ev_dscr_empty` for one cycle if `buf_more` is 1.
- R10: `cmd_stop` while working sets `park` and drops `mem_req` and `dsc_valid` on the next cycle. The history is left unchanged.
- R11: `chan_rst` returns the walker to idle on the next cycle. It has priority over start.
- R12: While `dsc_valid` is 1, `dsc_buf` is word 1, `dsc_len` is word 0 bits 11:0, and `dsc_size` is word 0 bits 23:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_rst | input | 1 | Channel reset, returns the walker to idle |
| start_addr | input | START_W | Low bits of the first descriptor address |
| own_chk_en | input | 1 | Enable owner bit checking |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_restart | input | 1 | Restart command pulse |
| park | output | 1 | 1 while idle |
| mem_req | output | 1 | Read request to descriptor memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| buf_done | input | 1 | Datapath finished the current buffer |
| buf_more | input | 1 | Transfer still has data beyond this buffer |
| dsc_valid | output | 1 | A validated descriptor is held |
| dsc_buf | output | ADDR_W | Buffer address of the held descriptor |
| dsc_len | output | 12 | Length field of the held descriptor |
| dsc_size | output | 12 | Size field of the held descriptor |
| hist_cur | output | ADDR_W | Most recently accepted descriptor address |
| hist_prev | output | ADDR_W | Accepted address before that |
| hist_old | output | ADDR_W | Accepted address two before |
| eof_addr | output | ADDR_W | Address of the last accepted end-of-frame descriptor |
| ev_dscr_err | output | 1 | Descriptor rejected pulse |
| ev_dscr_empty | output | 1 | Chain exhausted with data pending pulse |
| ev_eof | output | 1 | End-of-frame descriptor accepted pulse |

## Verification
The bench builds the walker with a 32-bit address, a 20-bit start field and a nonzero `ADDR_HI` of 12'h3FC. A fetch that drops the upper bits, or that fails to join them to `start_addr`, therefore reads the wrong words and shows up at once. The memory model answers with a latency of two cycles, so each request waits for its data. Because the descriptors hold full 32-bit next pointers, the chain, restart and history checks compare complete addresses rather than only the low bits.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 12;
  localparam int OWN_BIT  = 31;
  localparam int EOF_BIT  = 30;
  localparam int SIZE_LSB = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_HOLD} lnk_state_e;

  // compacted first word: reserved bits are not stored
  typedef struct packed {
    logic               owner;
    logic               eof;
    logic [FIELD_W-1:0] size;
    logic [FIELD_W-1:0] len;
  } dsc_head_t;
endpackage

// File: rtl/dlw_fetch.sv
module dlw_fetch import dlw_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                abort,
  input  logic [ADDR_W-1:0]   go_addr,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                done,
  output dsc_head_t           w0,
  output logic [WORD_W-1:0]   w1,
  output logic [WORD_W-1:0]   w2
);
  localparam int IDX_W = 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_W / 8);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      idx      <= '0;
      w0       <= '0;
      w1       <= '0;
      w2       <= '0;
    end else if (abort) begin
      mem_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        mem_req  <= 1'b1;
        mem_addr <= go_addr;
        idx      <= '0;
      end else if (mem_req && mem_rvalid) begin
        case (idx)
          2'd0:    w0 <= {mem_rdata[OWN_BIT], mem_rdata[EOF_BIT],
                          mem_rdata[SIZE_LSB+FIELD_W-1:SIZE_LSB], mem_rdata[FIELD_W-1:0]};
          2'd1:    w1 <= mem_rdata;
          default: w2 <= mem_rdata;
        endcase
        if (idx == LAST_IDX) begin
          mem_req <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          mem_addr <= mem_addr + STRIDE;
        end
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid && !abort) |=> (mem_req && $stable(mem_addr)));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
endmodule

// File: rtl/dlw_desc_chk.sv
module dlw_desc_chk import dlw_pkg::*; (
  input  dsc_head_t          w0,
  input  logic [WORD_W-1:0]  w1,
  input  logic [WORD_W-1:0]  w2,
  input  logic               own_chk_en,
  output logic               bad
);
  logic own_bad;
  logic align_bad;

  always_comb begin
    own_bad   = own_chk_en && !w0.owner;
    align_bad = (w1[1:0] != 2'b00) || (w2[1:0] != 2'b00);
    bad       = own_bad || align_bad;
  end
endmodule

// File: rtl/dlw_hist.sv
module dlw_hist #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              push_eof,
  output logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] prev,
  output logic [ADDR_W-1:0] old,
  output logic [ADDR_W-1:0] eof_addr,
  output logic              ev_eof
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      prev     <= '0;
      old      <= '0;
      eof_addr <= '0;
      ev_eof   <= 1'b0;
    end else begin
      ev_eof <= 1'b0;
      if (push) begin
        old  <= prev;
        prev <= cur;
        cur  <= push_addr;
        if (push_eof) begin
          eof_addr <= push_addr;
          ev_eof   <= 1'b1;
        end
      end
    end
  end

  // R6
  eof_match_chk: assert property (@(posedge clk) disable iff (rst)
    ev_eof |-> (eof_addr == cur));

  // R5
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(old) |-> (old == $past(prev)));
endmodule

// File: rtl/dma_link_walker.sv
module dma_link_walker import dlw_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int START_W = 20,
  parameter logic [ADDR_W-START_W-1:0] ADDR_HI = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_rst,
  input  logic [START_W-1:0] start_addr,
  input  logic               own_chk_en,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic               cmd_restart,
  output logic               park,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  input  logic               buf_done,
  input  logic               buf_more,
  output logic               dsc_valid,
  output logic [ADDR_W-1:0]  dsc_buf,
  output logic [11:0]        dsc_len,
  output logic [11:0]        dsc_size,
  output logic [ADDR_W-1:0]  hist_cur,
  output logic [ADDR_W-1:0]  hist_prev,
  output logic [ADDR_W-1:0]  hist_old,
  output logic [ADDR_W-1:0]  eof_addr,
  output logic               ev_dscr_err,
  output logic               ev_dscr_empty,
  output logic               ev_eof
);
  lnk_state_e         state;
  logic [ADDR_W-1:0]  dsc_addr;
  logic               halt;
  logic               go_first, go_re, go_next, fetch_go;
  logic [ADDR_W-1:0]  fetch_addr;
  logic               fetch_done;
  dsc_head_t          w0;
  logic [WORD_W-1:0]  w1, w2;
  logic               bad;
  logic               push;
  logic [ADDR_W-1:0]  next_ptr;

  assign next_ptr = w2[ADDR_W-1:0];

  always_comb begin
    halt     = chan_rst || cmd_stop;
    go_first = (state == ST_IDLE) && !halt && cmd_start;
    go_re    = (state == ST_IDLE) && !halt && !cmd_start && cmd_restart;
    go_next  = (state == ST_HOLD) && !halt && buf_done && (next_ptr != '0);
    fetch_go = go_first || go_re || go_next;
    if (go_first)   fetch_addr = {ADDR_HI, start_addr};
    else if (go_re) fetch_addr = hist_cur;
    else            fetch_addr = next_ptr;
    push     = (state == ST_FETCH) && !halt && fetch_done && !bad;
  end

  dlw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .abort(halt), .go_addr(fetch_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(fetch_done), .w0(w0), .w1(w1), .w2(w2)
  );

  dlw_desc_chk u_chk (
    .w0(w0), .w1(w1), .w2(w2), .own_chk_en(own_chk_en), .bad(bad)
  );

  dlw_hist #(.ADDR_W(ADDR_W)) u_hist (
    .clk(clk), .rst(rst), .push(push), .push_addr(dsc_addr), .push_eof(w0.eof),
    .cur(hist_cur), .prev(hist_prev), .old(hist_old), .eof_addr(eof_addr),
    .ev_eof(ev_eof)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      park          <= 1'b1;
      dsc_valid     <= 1'b0;
      dsc_addr      <= '0;
      ev_dscr_err   <= 1'b0;
      ev_dscr_empty <= 1'b0;
    end else begin
      ev_dscr_err   <= 1'b0;
      ev_dscr_empty <= 1'b0;
      if (halt) begin
        state     <= ST_IDLE;
        park      <= 1'b1;
        dsc_valid <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (fetch_go) begin
            state    <= ST_FETCH;
            park     <= 1'b0;
            dsc_addr <= fetch_addr;
          end
          ST_FETCH: if (fetch_done) begin
            if (bad) begin
              state       <= ST_IDLE;
              park        <= 1'b1;
              ev_dscr_err <= 1'b1;
            end else begin
              state     <= ST_HOLD;
              dsc_valid <= 1'b1;
            end
          end
          ST_HOLD: if (buf_done) begin
            dsc_valid <= 1'b0;
            if (fetch_go) begin
              state    <= ST_FETCH;
              dsc_addr <= fetch_addr;
            end else begin
              state         <= ST_IDLE;
              park          <= 1'b1;
              ev_dscr_empty <= buf_more;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign dsc_buf  = w1[ADDR_W-1:0];
  assign dsc_len  = w0.len;
  assign dsc_size = w0.size;

  // R1
  park_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    park |-> !mem_req);

  // R11
  chrst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    chan_rst |=> park);

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stop && !park) |=> (park && !mem_req && $stable(hist_cur)));

  // R3
  start_go_chk: assert property (@(posedge clk) disable iff (rst)
    (park && cmd_start && !cmd_stop && !chan_rst) |=> (!park && mem_req));

  // R7
  err_park_chk: assert property (@(posedge clk) disable iff (rst)
    ev_dscr_err |-> (park && !dsc_valid));

  // R9
  event_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_dscr_err, ev_dscr_empty, ev_eof}));
endmodule

// File: tb/dma_link_walker_tb.sv
`timescale 1ns/1ps
module dma_link_walker_tb;
  localparam int AW = 32;
  localparam int SW = 20;
  localparam logic [11:0] HI = 12'h3FC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_rst = 1'b0, own_chk_en = 1'b1;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_restart = 1'b0;
  logic [SW-1:0] start_addr = '0;
  logic buf_done = 1'b0, buf_more = 1'b0;
  logic park, mem_req, dsc_valid, ev_dscr_err, ev_dscr_empty, ev_eof;
  logic [AW-1:0] mem_addr, dsc_buf, hist_cur, hist_prev, hist_old, eof_addr;
  logic [11:0] dsc_len, dsc_size;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int n_err = 0, n_empty = 0, n_eof = 0;
  logic [31:0] mem [64];
  logic [31:0] req_log [64];
  int nlog = 0;
  logic pend = 1'b0;
  logic [5:0] paddr = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_link_walker #(.ADDR_W(AW), .START_W(SW), .ADDR_HI(HI)) u_dut (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .start_addr(start_addr),
    .own_chk_en(own_chk_en), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_restart(cmd_restart), .park(park), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .buf_done(buf_done),
    .buf_more(buf_more), .dsc_valid(dsc_valid), .dsc_buf(dsc_buf), .dsc_len(dsc_len),
    .dsc_size(dsc_size), .hist_cur(hist_cur), .hist_prev(hist_prev),
    .hist_old(hist_old), .eof_addr(eof_addr), .ev_dscr_err(ev_dscr_err),
    .ev_dscr_empty(ev_dscr_empty), .ev_eof(ev_eof)
  );

  // memory model: two-cycle latency, one request at a time
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      pend       <= 1'b0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (pend) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[paddr];
      pend       <= 1'b0;
    end else if (mem_req) begin
      pend          <= 1'b1;
      paddr         <= mem_addr[7:2];
      req_log[nlog] <= mem_addr;
      nlog          <= nlog + 1;
    end
  end

  // event pulse counters, updated between edges
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      n_err   += int'(ev_dscr_err);
      n_empty += int'(ev_dscr_empty);
      n_eof   += int'(ev_eof);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit s, input bit st, input bit rs, input bit cr, input bit bd);
    @(negedge clk);
    cmd_start = s; cmd_stop = st; cmd_restart = rs; chan_rst = cr; buf_done = bd;
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_restart = 0; chan_rst = 0; buf_done = 0;
  endtask

  task automatic settle(input string req);
    int n = 0;
    while (!(dsc_valid || park) && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({req, " settle"}, 64'(n < 40), 64'd1);
  endtask

  task automatic put(input int a, input logic [31:0] x0, input logic [31:0] x1, input logic [31:0] x2);
    mem[a/4] = x0; mem[a/4+1] = x1; mem[a/4+2] = x2;
  endtask

  function automatic logic [31:0] fa(input int off);
    return {HI, 20'(off)};
  endfunction

  task automatic t_reset();
    chk("R1 park", 64'(park), 1);
    chk("R1 req", 64'(mem_req), 0);
    chk("R1 valid", 64'(dsc_valid), 0);
    chk("R1 hist", {hist_cur, hist_old}, 0);
    chk("R1 eof", 64'(eof_addr), 0);
  endtask

  task automatic t_single();
    int l0 = nlog, e0 = n_eof;
    own_chk_en = 1; start_addr = 20'h00010;
    pulse(1, 0, 0, 0, 0);
    settle("R2");
    chk("R2 rd0", 64'(req_log[l0]), 64'(fa('h10)));
    chk("R2 rd1", 64'(req_log[l0+1]), 64'(fa('h14)));
    chk("R2 rd2", 64'(req_log[l0+2]), 64'(fa('h18)));
    chk("R12 valid", 64'(dsc_valid), 1);
    chk("R12 buf", 64'(dsc_buf), 64'h3FC01000);
    chk("R12 len/size", {dsc_len, dsc_size}, {12'h020, 12'h040});
    chk("R5 cur", 64'(hist_cur), 64'(fa('h10)));
    chk("R6 eof addr", 64'(eof_addr), 64'(fa('h10)));
    chk("R6 eof pulse", 64'(n_eof - e0), 1);
    buf_more = 0;
    pulse(0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R9 park end", 64'(park), 1);
  endtask

  task automatic t_chain();
    int e0 = n_eof, m0 = n_empty;
    start_addr = 20'h00020;
    pulse(1, 0, 0, 0, 0);
    settle("R9");
    chk("R5 B cur/prev", {hist_cur, hist_prev}, {fa('h20), fa('h10)});
    chk("R6 no eof on B", 64'(n_eof - e0), 0);
    start_addr = 20'h00040;
    pulse(1, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R3 ignored busy", {31'd0, park, dsc_buf}, {32'd0, 32'h3FC01100});
    buf_more = 1;
    pulse(0, 0, 0, 0, 1);
    settle("R9");
    chk("R9 next fetched", 64'(hist_cur), 64'(fa('h30)));
    chk("R5 triple", {hist_prev, hist_old}, {fa('h20), fa('h10)});
    chk("R6 eof C", 64'(eof_addr), 64'(fa('h30)));
    pulse(0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R9 empty pulse", 64'(n_empty - m0), 1);
    chk("R9 park", 64'(park), 1);
    buf_more = 0;
  endtask

  task automatic t_restart();
    int l0 = nlog;
    start_addr = 20'h00010;
    pulse(0, 0, 1, 0, 0);
    settle("R4");
    chk("R4 reread", 64'(req_log[l0]), 64'(fa('h30)));
    chk("R4 hist", {hist_cur, hist_prev}, {fa('h30), fa('h30)});
    chk("R5 old", 64'(hist_old), 64'(fa('h20)));
    pulse(0, 0, 0, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_owner();
    int r0 = n_err, e0 = n_eof;
    own_chk_en = 1; start_addr = 20'h00040;
    pulse(1, 0, 0, 0, 0);
    settle("R7");
    @(negedge clk);
    chk("R7 err pulse", 64'(n_err - r0), 1);
    chk("R7 park", {park, dsc_valid}, 2'b10);
    chk("R7 hist held", {hist_cur, hist_old}, {fa('h30), fa('h20)});
    chk("R7 eof held", {32'(n_eof - e0), eof_addr}, {32'd0, fa('h30)});
    own_chk_en = 0; start_addr = 20'h00060;
    pulse(1, 0, 0, 0, 0);
    settle("R7");
    chk("R7 owner ignored", {31'd0, dsc_valid, hist_cur}, {32'd1, fa('h60)});
    pulse(0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R7 err count", 64'(n_err - r0), 1);
  endtask

  task automatic t_malformed();
    int r0 = n_err;
    own_chk_en = 1; start_addr = 20'h00050;
    pulse(1, 0, 0, 0, 0);
    settle("R8");
    @(negedge clk);
    chk("R8 next misaligned", 64'(n_err - r0), 1);
    start_addr = 20'h00070;
    pulse(1, 0, 0, 0, 0);
    settle("R8");
    @(negedge clk);
    chk("R8 buf misaligned", 64'(n_err - r0), 2);
    chk("R8 hist held", 64'(hist_cur), 64'(fa('h60)));
  endtask

  task automatic t_stop();
    start_addr = 20'h00020;
    pulse(1, 0, 0, 0, 0);
    settle("R10");
    pulse(0, 1, 0, 0, 0);
    chk("R10 park", {park, mem_req, dsc_valid}, 3'b100);
    chk("R10 hist", {hist_cur, hist_prev}, {fa('h20), fa('h60)});
    chk("R10 old", 64'(hist_old), 64'(fa('h30)));
    pulse(1, 1, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R3 stop wins", {park, mem_req}, 2'b10);
  endtask

  task automatic t_chrst();
    start_addr = 20'h00010;
    pulse(1, 0, 0, 0, 0);
    settle("R11");
    chk("R11 working", 64'(park), 0);
    pulse(0, 0, 0, 1, 0);
    chk("R11 idle", {park, dsc_valid}, 2'b10);
    pulse(1, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk("R11 over start", {park, mem_req}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put('h10, 32'hC0040020, 32'h3FC01000, 32'h0);
    put('h20, 32'h80080080, 32'h3FC01100, 32'h3FC00030);
    put('h30, 32'hC0010008, 32'h3FC01200, 32'h0);
    put('h40, 32'h40010010, 32'h3FC01300, 32'h0);
    put('h50, 32'h80010010, 32'h3FC01400, 32'h3FC00022);
    put('h60, 32'h00020010, 32'h3FC01500, 32'h0);
    put('h70, 32'h80010010, 32'h3FC01601, 32'h0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_restart();
    t_owner();
    t_malformed();
    t_stop();
    t_chrst();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule